// File: doc/BRIEF.md
# Dual-Bank Architectural Register File with Sequential Clear

This block holds the architectural registers of a processor core: an integer bank and a floating-point bank of 32 entries each. The integer bank serves two operand reads per cycle and the floating-point bank serves three. Each bank takes one write per cycle. A read whose index matches a write in the same cycle returns the data being written, so a decode stage always sees the newest value without a separate forwarding path.

After reset the registers are not cleared at once. A counter zeroes one entry per cycle. While it runs, `ready` stays low so that the upstream stage holds off, and write requests are dropped. In the split build both banks clear in parallel over 32 cycles. A compile-time option (`MERGED=1`) folds both banks into one 64-entry array. There, the register kind supplies the top bit of a 6-bit index: integer registers sit at entries 32..63 and floating-point registers at entries 0..31. Each entry is as wide as the wider of the two banks, and clearing takes 64 cycles.

Top module: `arch_regfile`

## Requirements
- R1: In the split build, `ready` is low during reset and for the first 31 rising edges after reset is released. It is high from the 32nd rising edge on and stays high until the next reset.
- R2: In the merged build, `ready` rises on the 64th rising edge after reset is released and not before.
- R3: Once `ready` is high, every register of both banks reads zero until it is written.
- R4: An integer write at a rising edge (`iw_en`=1, index 1..31) is returned by both integer read ports from then on, until that index is written again.
- R5: A floating-point write is returned by all three floating-point read ports at the full width `FLEN`, including index 0.
- R6: A read whose index equals the index being written in the same cycle returns the new write data combinationally. This holds for both banks.
- R7: Integer index 0 always reads zero. A write to it has no effect, and it is never forwarded by the same-cycle bypass.
- R8: Write requests made while `ready` is low are ignored: the targeted registers read zero once `ready` is high.
- R9: The two banks are independent. Writing an index in one bank leaves the same index in the other bank unchanged, in both the split and the merged build.
- R10: In the merged build, integer reads return the low `XLEN` bits of the entry and floating-point reads return the full `FLEN` bits. The results are identical to the split build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; starts the clearing sequence |
| ready | output | 1 | High once clearing is done; the upstream stage may issue |
| iw_en | input | 1 | Integer write enable |
| iw_idx | input | 5 | Integer write index |
| iw_data | input | XLEN | Integer write data |
| ir_idx0 | input | 5 | Integer read port 0 index |
| ir_idx1 | input | 5 | Integer read port 1 index |
| ir_data0 | output | XLEN | Integer read port 0 data |
| ir_data1 | output | XLEN | Integer read port 1 data |
| fw_en | input | 1 | Floating-point write enable |
| fw_idx | input | 5 | Floating-point write index |
| fw_data | input | FLEN | Floating-point write data |
| fr_idx0 | input | 5 | Floating-point read port 0 index |
| fr_idx1 | input | 5 | Floating-point read port 1 index |
| fr_idx2 | input | 5 | Floating-point read port 2 index |
| fr_data0 | output | FLEN | Floating-point read port 0 data |
| fr_data1 | output | FLEN | Floating-point read port 1 data |
| fr_data2 | output | FLEN | Floating-point read port 2 data |

## Verification
Read data is combinational: it depends on the stored value and on the write presented in the same cycle. Each check therefore drives indices and write requests just after a falling edge and compares all five read ports a nanosecond later. The reference model commits the write only after that comparison, which matches the store at the following rising edge. `ready` is sampled at each falling edge after reset release. It is expected low up to the 31st (split) or 63rd (merged) edge and high from the 32nd (split) or 64th (merged) edge on. A split and a merged instance receive the same stimulus and are checked against the same model.

// File: rtl/arch_rf_pkg.sv
package arch_rf_pkg;

  function automatic int wmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int clear_depth(input int nreg, input bit merged);
    return merged ? 2 * nreg : nreg;
  endfunction

endpackage

// File: rtl/rf_clear_seq.sv
module rf_clear_seq #(
  parameter int DEPTH = 32,
  localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          clr_en,
  output logic [CW-1:0] clr_idx,
  output logic          ready
);
  logic [CW-1:0] cnt;
  logic          busy;
  logic          at_last;

  assign at_last = (cnt == CW'(DEPTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (at_last) busy <= 1'b0;
    end
  end

  assign clr_en  = busy;
  assign clr_idx = cnt;
  assign ready   = !busy;

  a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  a_r1_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && at_last) |=> ready);
  a_r1_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !at_last) |=> (!ready && clr_idx == $past(clr_idx) + 1'b1));
endmodule

// File: rtl/rf_array.sv
module rf_array #(
  parameter int NENT = 32,
  parameter int W    = 32,
  parameter int NRD  = 2,
  parameter int NWR  = 1,
  localparam int AW  = $clog2(NENT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_en,
  input  logic [AW-1:0]           clr_idx,
  input  logic [NWR-1:0]          we,
  input  logic [NWR-1:0][AW-1:0]  wa,
  input  logic [NWR-1:0][W-1:0]   wd,
  input  logic [NRD-1:0][AW-1:0]  ra,
  output logic [NRD-1:0][W-1:0]   rd
);
  logic [W-1:0]   mem [NENT];
  logic [NRD-1:0] byp_hit;
  logic           port0_shared;

  always_ff @(posedge clk) begin
    if (clr_en) begin
      mem[clr_idx] <= '0;
    end else begin
      for (int w = 0; w < NWR; w++) begin
        if (we[w]) mem[wa[w]] <= wd[w];
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NRD; r++) begin
      rd[r]      = mem[ra[r]];
      byp_hit[r] = 1'b0;
      for (int w = 0; w < NWR; w++) begin
        if (we[w] && wa[w] == ra[r]) begin
          rd[r]      = wd[w];
          byp_hit[r] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    port0_shared = 1'b0;
    for (int w = 1; w < NWR; w++) begin
      if (we[w] && wa[w] == wa[0]) port0_shared = 1'b1;
    end
  end

  // R4 / R5: a write on port 0 is held in storage after the edge
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we[0] && !clr_en && !port0_shared) |=> (mem[$past(wa[0])] == $past(wd[0])));
  // R6: a flagged bypass returns exactly the write data of a matching port
  a_r6_bypass_port0: assert property (@(posedge clk) disable iff (!rst_n)
    (we[0] && !port0_shared && byp_hit[0] && ra[0] == wa[0]) |-> (rd[0] == wd[0]));
endmodule

// File: rtl/arch_regfile.sv
module arch_regfile #(
  parameter int XLEN   = 32,
  parameter int FLEN   = 64,
  parameter int NREG   = 32,
  parameter bit MERGED = 1'b0,
  localparam int IW    = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            ready,
  input  logic            iw_en,
  input  logic [IW-1:0]   iw_idx,
  input  logic [XLEN-1:0] iw_data,
  input  logic [IW-1:0]   ir_idx0,
  input  logic [IW-1:0]   ir_idx1,
  output logic [XLEN-1:0] ir_data0,
  output logic [XLEN-1:0] ir_data1,
  input  logic            fw_en,
  input  logic [IW-1:0]   fw_idx,
  input  logic [FLEN-1:0] fw_data,
  input  logic [IW-1:0]   fr_idx0,
  input  logic [IW-1:0]   fr_idx1,
  input  logic [IW-1:0]   fr_idx2,
  output logic [FLEN-1:0] fr_data0,
  output logic [FLEN-1:0] fr_data1,
  output logic [FLEN-1:0] fr_data2
);
  import arch_rf_pkg::*;

  localparam int DEPTH = clear_depth(NREG, MERGED);
  localparam int DW    = $clog2(DEPTH);
  localparam int MW    = wmax(XLEN, FLEN);

  logic            int_we;
  logic            fp_we;
  logic            clr_en;
  logic [DW-1:0]   clr_idx;
  logic [XLEN-1:0] int_raw0, int_raw1;

  assign int_we = iw_en && ready && (iw_idx != '0);
  assign fp_we  = fw_en && ready;

  rf_clear_seq #(.DEPTH(DEPTH)) u_clear (
    .clk(clk), .rst_n(rst_n), .clr_en(clr_en), .clr_idx(clr_idx), .ready(ready)
  );

  generate
    if (MERGED) begin : g_merged
      logic [1:0]          m_we;
      logic [1:0][DW-1:0]  m_wa;
      logic [1:0][MW-1:0]  m_wd;
      logic [4:0][DW-1:0]  m_ra;
      logic [4:0][MW-1:0]  m_rd;

      always_comb begin
        m_we    = {fp_we, int_we};
        m_wa[0] = {1'b1, iw_idx};
        m_wa[1] = {1'b0, fw_idx};
        m_wd    = '0;
        m_wd[0][XLEN-1:0] = iw_data;
        m_wd[1][FLEN-1:0] = fw_data;
        m_ra[0] = {1'b1, ir_idx0};
        m_ra[1] = {1'b1, ir_idx1};
        m_ra[2] = {1'b0, fr_idx0};
        m_ra[3] = {1'b0, fr_idx1};
        m_ra[4] = {1'b0, fr_idx2};
      end

      rf_array #(.NENT(DEPTH), .W(MW), .NRD(5), .NWR(2)) u_store (
        .clk(clk), .rst_n(rst_n), .clr_en(clr_en), .clr_idx(clr_idx),
        .we(m_we), .wa(m_wa), .wd(m_wd), .ra(m_ra), .rd(m_rd)
      );

      assign int_raw0 = m_rd[0][XLEN-1:0];
      assign int_raw1 = m_rd[1][XLEN-1:0];
      assign fr_data0 = m_rd[2][FLEN-1:0];
      assign fr_data1 = m_rd[3][FLEN-1:0];
      assign fr_data2 = m_rd[4][FLEN-1:0];
    end else begin : g_split
      logic [1:0][XLEN-1:0] i_rd;
      logic [2:0][FLEN-1:0] f_rd;

      rf_array #(.NENT(NREG), .W(XLEN), .NRD(2), .NWR(1)) u_int (
        .clk(clk), .rst_n(rst_n), .clr_en(clr_en), .clr_idx(clr_idx),
        .we(int_we), .wa(iw_idx), .wd(iw_data),
        .ra({ir_idx1, ir_idx0}), .rd(i_rd)
      );

      rf_array #(.NENT(NREG), .W(FLEN), .NRD(3), .NWR(1)) u_fp (
        .clk(clk), .rst_n(rst_n), .clr_en(clr_en), .clr_idx(clr_idx),
        .we(fp_we), .wa(fw_idx), .wd(fw_data),
        .ra({fr_idx2, fr_idx1, fr_idx0}), .rd(f_rd)
      );

      assign int_raw0 = i_rd[0];
      assign int_raw1 = i_rd[1];
      assign fr_data0 = f_rd[0];
      assign fr_data1 = f_rd[1];
      assign fr_data2 = f_rd[2];
    end
  endgenerate

  assign ir_data0 = (ir_idx0 == '0) ? '0 : int_raw0;
  assign ir_data1 = (ir_idx1 == '0) ? '0 : int_raw1;

  // R7: integer index 0 is zero on both ports, even while it is being written
  a_r7_x0_port0: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ir_idx0 == '0) |-> (ir_data0 == '0));
  a_r7_x0_port1: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ir_idx1 == '0) |-> (ir_data1 == '0));
  // R8: no write reaches storage before clearing completes
  a_r8_hold_writes: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!int_we && !fp_we && clr_en));
endmodule

// File: tb/arch_regfile_test.sv
module arch_regfile_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        iw_en = 0, fw_en = 0;
  logic [4:0]  iw_idx = 0, fw_idx = 0;
  logic [31:0] iw_data = 0;
  logic [63:0] fw_data = 0;
  logic [4:0]  ir_idx0 = 0, ir_idx1 = 0, fr_idx0 = 0, fr_idx1 = 0, fr_idx2 = 0;

  logic        rdy_s, rdy_m;
  logic [31:0] ia_s, ib_s, ia_m, ib_m;
  logic [63:0] fa_s, fb_s, fc_s, fa_m, fb_m, fc_m;

  arch_regfile #(.XLEN(32), .FLEN(64), .NREG(32), .MERGED(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .ready(rdy_s),
    .iw_en(iw_en), .iw_idx(iw_idx), .iw_data(iw_data),
    .ir_idx0(ir_idx0), .ir_idx1(ir_idx1), .ir_data0(ia_s), .ir_data1(ib_s),
    .fw_en(fw_en), .fw_idx(fw_idx), .fw_data(fw_data),
    .fr_idx0(fr_idx0), .fr_idx1(fr_idx1), .fr_idx2(fr_idx2),
    .fr_data0(fa_s), .fr_data1(fb_s), .fr_data2(fc_s));

  arch_regfile #(.XLEN(32), .FLEN(64), .NREG(32), .MERGED(1'b1)) uut_m (
    .clk(clk), .rst_n(rst_n), .ready(rdy_m),
    .iw_en(iw_en), .iw_idx(iw_idx), .iw_data(iw_data),
    .ir_idx0(ir_idx0), .ir_idx1(ir_idx1), .ir_data0(ia_m), .ir_data1(ib_m),
    .fw_en(fw_en), .fw_idx(fw_idx), .fw_data(fw_data),
    .fr_idx0(fr_idx0), .fr_idx1(fr_idx1), .fr_idx2(fr_idx2),
    .fr_data0(fa_m), .fr_data1(fb_m), .fr_data2(fc_m));

  int total = 0;
  int bad = 0;
  logic [31:0] im [32];
  logic [63:0] fm [32];

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_int(input logic [4:0] idx);
    if (idx == 0) return 32'h0;
    if (iw_en && iw_idx == idx) return iw_data;
    return im[idx];
  endfunction

  function automatic logic [63:0] exp_fp(input logic [4:0] idx);
    if (fw_en && fw_idx == idx) return fw_data;
    return fm[idx];
  endfunction

  function automatic string tag_int(input logic [4:0] idx);
    if (idx == 0) return "R7 int x0";
    if (iw_en && iw_idx == idx) return "R6 int bypass";
    return "R4 int read";
  endfunction

  function automatic string tag_fp(input logic [4:0] idx);
    if (fw_en && fw_idx == idx) return "R6 fp bypass";
    return "R5 fp read";
  endfunction

  task automatic compare_all(input string pfx);
    chk({pfx, " ", tag_int(ir_idx0), " split p0"}, {32'h0, ia_s}, {32'h0, exp_int(ir_idx0)});
    chk({pfx, " ", tag_int(ir_idx1), " split p1"}, {32'h0, ib_s}, {32'h0, exp_int(ir_idx1)});
    chk({pfx, " ", tag_int(ir_idx0), " R10 merged p0"}, {32'h0, ia_m}, {32'h0, exp_int(ir_idx0)});
    chk({pfx, " ", tag_int(ir_idx1), " R10 merged p1"}, {32'h0, ib_m}, {32'h0, exp_int(ir_idx1)});
    chk({pfx, " ", tag_fp(fr_idx0), " split p0"}, fa_s, exp_fp(fr_idx0));
    chk({pfx, " ", tag_fp(fr_idx1), " split p1"}, fb_s, exp_fp(fr_idx1));
    chk({pfx, " ", tag_fp(fr_idx2), " split p2"}, fc_s, exp_fp(fr_idx2));
    chk({pfx, " ", tag_fp(fr_idx0), " R10 merged p0"}, fa_m, exp_fp(fr_idx0));
    chk({pfx, " ", tag_fp(fr_idx1), " R10 merged p1"}, fb_m, exp_fp(fr_idx1));
    chk({pfx, " ", tag_fp(fr_idx2), " R10 merged p2"}, fc_m, exp_fp(fr_idx2));
  endtask

  // model commit: the store that the next rising edge performs
  task automatic commit();
    if (iw_en && iw_idx != 0) im[iw_idx] = iw_data;
    if (fw_en) fm[fw_idx] = fw_data;
  endtask

  task automatic step(input string pfx);
    #1;
    compare_all(pfx);
    commit();
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin im[i] = '0; fm[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset split", {63'h0, rdy_s}, 64'h0);
    chk("R2 ready low in reset merged", {63'h0, rdy_m}, 64'h0);

    // R8: writes presented while clearing
    iw_en = 1; iw_idx = 5; iw_data = 32'hDEAD_BEEF;
    fw_en = 1; fw_idx = 7; fw_data = 64'hCAFE_F00D_1234_5678;
    rst_n = 1'b1;
    for (int k = 1; k <= 70; k++) begin
      @(negedge clk);
      if (k == 28) begin iw_en = 0; fw_en = 0; end
      if (k == 31 || k == 32 || k == 33 || k == 70)
        chk("R1 ready timing split", {63'h0, rdy_s}, {63'h0, (k >= 32)});
      if (k == 63 || k == 64 || k == 70)
        chk("R2 ready timing merged", {63'h0, rdy_m}, {63'h0, (k >= 64)});
    end

    // R3 / R8: everything reads zero after clearing
    for (int i = 0; i < 32; i++) begin
      ir_idx0 = 5'(i); ir_idx1 = 5'(31 - i);
      fr_idx0 = 5'(i); fr_idx1 = 5'(31 - i); fr_idx2 = 5'(i);
      #1;
      chk("R3 cleared int split", {32'h0, ia_s}, 64'h0);
      chk("R3 cleared int merged", {32'h0, ia_m}, 64'h0);
      chk("R3 cleared fp split", fa_s, 64'h0);
      chk("R3 cleared fp merged", fb_m, 64'h0);
      @(negedge clk);
    end
    ir_idx0 = 5; fr_idx0 = 7; #1;
    chk("R8 int write during clear ignored", {32'h0, ia_m | ia_s}, 64'h0);
    chk("R8 fp write during clear ignored", fa_m | fa_s, 64'h0);
    @(negedge clk);

    // R9: same index in both banks, same cycle
    iw_en = 1; iw_idx = 9; iw_data = 32'h1111_2222;
    fw_en = 1; fw_idx = 9; fw_data = 64'h9999_8888_7777_6666;
    ir_idx0 = 9; fr_idx0 = 9; fr_idx1 = 3;
    step("R9 same index");
    iw_en = 0; fw_en = 0;
    #1;
    chk("R9 int kept", {32'h0, ia_m}, 64'h0000_0000_1111_2222);
    chk("R9 fp kept", fa_m, 64'h9999_8888_7777_6666);
    chk("R9 int kept split", {32'h0, ia_s}, 64'h0000_0000_1111_2222);
    @(negedge clk);

    // R7: write to x0 with bypass-shaped read
    iw_en = 1; iw_idx = 0; iw_data = 32'hFFFF_FFFF; ir_idx0 = 0; ir_idx1 = 0;
    step("R7 x0 write");
    iw_en = 0;
    step("R7 x0 after");

    // R5: fp index 0 is a normal register
    fw_en = 1; fw_idx = 0; fw_data = 64'hA5A5_0000_FFFF_0001;
    fr_idx0 = 0; fr_idx1 = 0; fr_idx2 = 0;
    step("R5 f0 write");
    fw_en = 0;
    step("R5 f0 after");

    // mixed pseudo-random traffic with frequent index collisions
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      iw_en = r[0]; fw_en = r[1];
      iw_idx  = r[2] ? 5'($urandom % 4) : 5'($urandom);
      fw_idx  = r[3] ? 5'($urandom % 4) : 5'($urandom);
      iw_data = $urandom;
      fw_data = {$urandom, $urandom};
      ir_idx0 = r[4] ? 5'($urandom % 4) : 5'($urandom);
      ir_idx1 = r[5] ? 5'($urandom % 4) : 5'($urandom);
      fr_idx0 = r[6] ? 5'($urandom % 4) : 5'($urandom);
      fr_idx1 = r[7] ? 5'($urandom % 4) : 5'($urandom);
      fr_idx2 = r[8] ? 5'($urandom % 4) : 5'($urandom);
      step("mix");
    end
    iw_en = 0; fw_en = 0;
    #1;
    chk("R1 ready still high split", {63'h0, rdy_s}, 64'h1);
    chk("R2 ready still high merged", {63'h0, rdy_m}, 64'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule